// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a down-counting watchdog that sits on a simple single-cycle register bus. Software arms it by setting a count and a set of enable bits. It must then keep reloading the count before the count runs out. While the count is zero, the block raises an interrupt and/or pulls an active-low reset request, depending on which enables are set.

The count and enable registers are write-protected. A write to either one lands only while the key register holds the unlock value 32'h0000_482E. Software writes the key, changes the protected registers, and then writes any other value to the key to lock them again.

A sticky status flag records that the watchdog reached zero while the reset output was enabled. The flag lives in the power-on (cold) reset domain, so it survives the ordinary reset that the watchdog itself may trigger. Software reads the flag after reboot and clears it by writing 1.

Top module: `kwdt_top`

## Requirements
- R1: While `rst_n` is low, count reads all ones, the enable and key registers read 0, `wd_irq` is 0 and `wd_rst_n` is 1.
- R2: A bus write to count (word 0) or enable (word 1) has no effect unless the key register equals 32'h0000_482E at that clock edge.
- R3: The key register (word 2) accepts every write, reads back the last value written, and any value other than 32'h0000_482E relocks words 0 and 1.
- R4: With count enable (enable bit 0) set, the count falls by one on every clock; on reaching zero it stays at zero.
- R5: With count enable clear, the count holds its value.
- R6: `wd_irq` is 1 exactly while the count is zero and interrupt enable (enable bit 1) is set.
- R7: `wd_rst_n` is 0 exactly while the count is zero and reset enable (enable bit 2) is set.
- R8: An allowed count write in the same cycle as a decrement wins, and a nonzero write releases both outputs from the next cycle.
- R9: The status flag (word 3, bit 0) is set after any clock edge at which the count is zero with reset enable set. Writing 1 to bit 0 clears it unless the set condition holds in the same cycle. Writing 0 has no effect.
- R10: The status flag is unchanged by `rst_n` and is cleared only by `cold_rst_n` low.
- R11: Reads of word addresses above 3 return 0. Reads of count, enable and key need no unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| cold_rst_n | input | 1 | Active-low power-on reset, also clears status |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from address |
| wd_irq | output | 1 | Watchdog interrupt, active high |
| wd_rst_n | output | 1 | Watchdog reset request, active low |

## Verification
The assertions check on every cycle the counter's step rules: decrement by one, hold at zero, hold when disabled. They also check that a locked enable write leaves the enables unchanged, that both outputs stay quiet while the count is nonzero, and that the status flag is set by a zero count with reset enabled and held otherwise. Only the bench scenarios can show certain behaviours. These are key readback and relocking, the priority of a count write over the decrement as seen through a readback, status surviving a system reset but not a cold reset, and zero reads from unmapped addresses.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   typedef enum logic [1:0] {
      WORD_COUNT  = 2'd0,
      WORD_ENABLE = 2'd1,
      WORD_KEY    = 2'd2,
      WORD_STATUS = 2'd3
   } wd_word_e;

   // bit 0 count enable, bit 1 interrupt enable, bit 2 reset enable
   typedef struct packed {
      logic rst_en;
      logic irq_en;
      logic cnt_en;
   } wd_ctrl_t;

   localparam int CTRL_BITS = $bits(wd_ctrl_t);

endpackage

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o
);

   localparam logic [CNT_W-1:0] CNT_INIT = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= CNT_INIT;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_en && (cnt_q != '0))
         cnt_q <= cnt_q - CNT_ONE;
   end

   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == '0);

   assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

   assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_o && !load) |=> zero_o);

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/kwdt_status.sv
module kwdt_status (
   input  logic clk,
   input  logic cold_rst_n,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n)
         flag_q <= 1'b0;
      else if (set_i)
         flag_q <= 1'b1;
      else if (clr_i)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   assert_status_set_R9: assert property (@(posedge clk) disable iff (!cold_rst_n || !rst_n)
      set_i |=> flag_o);

   assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int              DATA_W     = 32,
   parameter int              ADDR_W     = 4,
   parameter int              CNT_W      = 32,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = DATA_W'(32'h0000_482E)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              status_val,
   output wd_ctrl_t          ctrl_o,
   output logic              cnt_load_o,
   output logic              status_clr_o,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(WORD_COUNT);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(WORD_ENABLE);
   localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(WORD_KEY);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(WORD_STATUS);

   logic [DATA_W-1:0] key_q;
   wd_ctrl_t          ctrl_q;
   logic              wr_stb;
   logic              unlocked;
   logic              ctrl_wr;
   logic [DATA_W-1:0] cnt_ext;

   assign wr_stb       = bus_sel && bus_wr;
   assign unlocked     = (key_q == UNLOCK_KEY);
   assign ctrl_wr      = wr_stb && (bus_addr == A_ENABLE) && unlocked;
   assign cnt_load_o   = wr_stb && (bus_addr == A_COUNT) && unlocked;
   assign status_clr_o = wr_stb && (bus_addr == A_STATUS) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         key_q <= '0;
      else if (wr_stb && (bus_addr == A_KEY))
         key_q <= bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (ctrl_wr)
         ctrl_q <= wd_ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
   end

   assign ctrl_o = ctrl_q;

   generate
      if (CNT_W == DATA_W) begin : g_cnt_full
         assign cnt_ext = cnt_val;
      end else begin : g_cnt_pad
         assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt_val};
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_COUNT)
         bus_rdata = cnt_ext;
      else if (bus_addr == A_ENABLE)
         bus_rdata = DATA_W'(ctrl_q);
      else if (bus_addr == A_KEY)
         bus_rdata = key_q;
      else if (bus_addr == A_STATUS)
         bus_rdata = DATA_W'(status_val);
   end

   assert_locked_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && bus_addr == A_ENABLE && key_q != UNLOCK_KEY) |=> (ctrl_q == $past(ctrl_q)));

   assert_key_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && bus_addr == A_KEY) |=> (key_q == $past(bus_wdata)));

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                ADDR_W     = 4,
   parameter int                CNT_W      = 32,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = DATA_W'(32'h0000_482E)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cold_rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wd_irq,
   output logic              wd_rst_n
);

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("kwdt_top: CNT_W must be within 2..DATA_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("kwdt_top: ADDR_W must be at least 2");
      end
      if (DATA_W < CTRL_BITS) begin : g_bad_data_w
         $error("kwdt_top: DATA_W too narrow for the enable field");
      end
   endgenerate

   wd_ctrl_t         ctrl;
   logic             cnt_load;
   logic             status_clr;
   logic             status_flag;
   logic [CNT_W-1:0] cnt;
   logic             cnt_zero;
   logic             alarm_rst;

   kwdt_regs #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .UNLOCK_KEY(UNLOCK_KEY)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .cnt_val     (cnt),
      .status_val  (status_flag),
      .ctrl_o      (ctrl),
      .cnt_load_o  (cnt_load),
      .status_clr_o(status_clr),
      .bus_rdata   (bus_rdata)
   );

   kwdt_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (ctrl.cnt_en),
      .load    (cnt_load),
      .load_val(bus_wdata[CNT_W-1:0]),
      .cnt_o   (cnt),
      .zero_o  (cnt_zero)
   );

   assign alarm_rst = cnt_zero && ctrl.rst_en;

   kwdt_status u_status (
      .clk       (clk),
      .cold_rst_n(cold_rst_n),
      .rst_n     (rst_n),
      .set_i     (alarm_rst),
      .clr_i     (status_clr),
      .flag_o    (status_flag)
   );

   assign wd_irq   = cnt_zero && ctrl.irq_en;
   assign wd_rst_n = !alarm_rst;

   assert_quiet_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> (!wd_irq && wd_rst_n));

   assert_release_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_load && bus_wdata[CNT_W-1:0] != '0) |=> (!wd_irq && wd_rst_n));

endmodule

// File: tb/kwdt_top_test.sv
module kwdt_top_test;

   localparam int DW = 32;
   localparam int AW = 4;
   localparam logic [31:0] KEY = 32'h0000_482E;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cold_rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          wd_irq;
   logic          wd_rst_n;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // behavioural reference model
   logic [31:0] m_cnt;
   logic [2:0]  m_en;
   logic [31:0] m_key;
   logic        m_st;

   always #5 clk = ~clk;

   kwdt_top uut (
      .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wd_irq(wd_irq), .wd_rst_n(wd_rst_n)
   );

   always @(posedge clk) begin
      logic [31:0] n_cnt;
      logic [2:0]  n_en;
      logic [31:0] n_key;
      logic        n_st;
      logic        wr;
      logic        unl;
      wr    = bus_sel && bus_wr;
      unl   = (m_key == KEY);
      n_cnt = m_cnt;
      n_en  = m_en;
      n_key = m_key;
      n_st  = m_st;
      if (wr && bus_addr == 4'd0 && unl)
         n_cnt = bus_wdata;
      else if (m_en[0] && m_cnt != 0)
         n_cnt = m_cnt - 1;
      if (wr && bus_addr == 4'd1 && unl)
         n_en = bus_wdata[2:0];
      if (wr && bus_addr == 4'd2)
         n_key = bus_wdata;
      if (m_cnt == 0 && m_en[2])
         n_st = 1'b1;
      else if (wr && bus_addr == 4'd3 && bus_wdata[0])
         n_st = 1'b0;
      if (!rst_n) begin
         n_cnt = 32'hFFFF_FFFF;
         n_en  = 3'b000;
         n_key = 32'h0;
      end
      if (!cold_rst_n)
         n_st = 1'b0;
      m_cnt = n_cnt;
      m_en  = n_en;
      m_key = n_key;
      m_st  = n_st;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // every-clock comparison of the outputs against the model
   always @(negedge clk) begin
      if (rst_n && cold_rst_n && !done) begin
         check("R6 irq vs model", {31'd0, wd_irq}, {31'd0, (m_cnt == 0 && m_en[1])});
         check("R7 rst_n vs model", {31'd0, wd_rst_n}, {31'd0, !(m_cnt == 0 && m_en[2])});
      end
   end

   task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
      bus_sel   = 1'b1;
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0;
      bus_wr  = 1'b0;
   endtask

   task automatic read_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
      bus_sel  = 1'b1;
      bus_wr   = 1'b0;
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
      bus_sel = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cold_rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      read_chk("R1 count reset", 4'd0, 32'hFFFF_FFFF);
      read_chk("R1 enable reset", 4'd1, 32'h0);
      read_chk("R1 key reset", 4'd2, 32'h0);
      read_chk("R10 status after cold", 4'd3, 32'h0);
      check("R1 irq idle", {31'd0, wd_irq}, 32'd0);
      check("R1 rst_n idle", {31'd0, wd_rst_n}, 32'd1);

      // R2 locked writes
      write_reg(4'd0, 32'd10);
      read_chk("R2 locked count write", 4'd0, 32'hFFFF_FFFF);
      write_reg(4'd1, 32'd7);
      read_chk("R2 locked enable write", 4'd1, 32'h0);

      // R3 unlock, arm, relock
      write_reg(4'd2, KEY);
      read_chk("R3 key readback", 4'd2, KEY);
      write_reg(4'd0, 32'd5);
      write_reg(4'd1, 32'd3);           // count + irq
      write_reg(4'd2, 32'h1234_0000);   // relock, count 5->4
      read_chk("R3 key other value", 4'd2, 32'h1234_0000);
      write_reg(4'd0, 32'd9);           // locked, count 4->3
      read_chk("R2 R4 locked write while counting", 4'd0, 32'd3);
      write_reg(4'd1, 32'd0);           // locked, count 3->2
      read_chk("R2 enable kept when locked", 4'd1, 32'd3);
      repeat (4) @(negedge clk);
      read_chk("R4 count floors at zero", 4'd0, 32'd0);
      check("R6 irq at zero", {31'd0, wd_irq}, 32'd1);
      check("R7 rst_n high without enable", {31'd0, wd_rst_n}, 32'd1);
      read_chk("R9 no status without reset enable", 4'd3, 32'd0);

      // R8 reload releases outputs, R5 hold
      write_reg(4'd2, KEY);
      write_reg(4'd0, 32'd3);
      read_chk("R8 reload value", 4'd0, 32'd3);
      check("R8 irq released", {31'd0, wd_irq}, 32'd0);
      write_reg(4'd1, 32'd0);           // count 3->2 at this edge
      repeat (3) @(negedge clk);
      read_chk("R5 hold when disabled", 4'd0, 32'd2);
      write_reg(4'd1, 32'd1);
      write_reg(4'd0, 32'h40);          // write wins over decrement
      read_chk("R8 write beats decrement", 4'd0, 32'h40);

      // R7 R9 reset output and status
      write_reg(4'd0, 32'd2);
      write_reg(4'd1, 32'd5);           // count + reset, count 2->1
      repeat (3) @(negedge clk);
      check("R7 rst_n asserted", {31'd0, wd_rst_n}, 32'd0);
      check("R6 irq off without enable", {31'd0, wd_irq}, 32'd0);
      read_chk("R9 status set", 4'd3, 32'd1);
      write_reg(4'd3, 32'd0);
      read_chk("R9 write 0 no effect", 4'd3, 32'd1);
      write_reg(4'd3, 32'd1);           // set still active at this edge
      read_chk("R9 set beats clear", 4'd3, 32'd1);
      write_reg(4'd0, 32'h100);
      check("R8 rst_n released", {31'd0, wd_rst_n}, 32'd1);
      write_reg(4'd3, 32'd1);
      read_chk("R9 write 1 clears", 4'd3, 32'd0);

      // R10 status across resets
      write_reg(4'd0, 32'd1);
      repeat (3) @(negedge clk);
      read_chk("R10 status set again", 4'd3, 32'd1);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      read_chk("R10 status survives rst_n", 4'd3, 32'd1);
      read_chk("R1 count after rst_n", 4'd0, 32'hFFFF_FFFF);
      read_chk("R1 key after rst_n", 4'd2, 32'h0);
      cold_rst_n = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      cold_rst_n = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      read_chk("R10 cold reset clears status", 4'd3, 32'd0);

      // R11 unmapped addresses
      read_chk("R11 unmapped 5", 4'd5, 32'd0);
      read_chk("R11 unmapped 15", 4'd15, 32'd0);

      @(negedge clk);
      summary();
   end

endmodule